// File: doc/BRIEF.md
# PWM Fault Monitor and Output Shutdown

This block watches a PWM output stage for fault conditions and, when one occurs, latches a fault flag, optionally requests an interrupt and optionally takes the PWM pads off the bus. It has two fault sources: the result of an analog comparator and an external fault pin. Each source has its own enable and its own choice of active edge. A master enable gates both sources together. The comparator and the PWM waveform generator are outside the block.

Both inputs are asynchronous. They pass through a synchronizer chain, and a fault is an edge of the synchronized value in the selected direction. Once set, the flag stays set until software clears it with a one-cycle clear pulse. While the flag is set and shutdown mode is selected, every channel whose output enable is set has its pad drive removed. The pads drive again as soon as the flag clears.

Top module: `pwm_fault_guard`

## Requirements
- R1: With `fd_en` at 0, no edge on either source sets `fault_flag`.
- R2: With `cmp_en` at 1, a rising edge on `cmp_in` is a fault when `cmp_fall` is 0, and a falling edge is a fault when `cmp_fall` is 1. The opposite edge is not a fault, and with `cmp_en` at 0 the comparator input is ignored.
- R3: With `pin_en` at 1, a rising edge on `flt_in` is a fault when `pin_fall` is 0, and a falling edge is a fault when `pin_fall` is 1. The opposite edge is not a fault, and with `pin_en` at 0 the pin is ignored.
- R4: An input change made between two clock edges shows on `fault_flag` after the third rising clock edge that follows it, and not after the second.
- R5: A fault sets `fault_flag` whatever the value of `irq_en`. `irq` is high exactly while `fault_flag` and `irq_en` are both 1.
- R6: While `fault_flag` and `hiz_mode` are both 1, `pad_drive` is all zeros. Otherwise `pad_drive` equals `ch_oe`, and a bit of `pad_drive` is never 1 where `ch_oe` is 0.
- R7: A one-cycle `flag_clr` pulse clears `fault_flag` at the next clock edge, and the pads return to normal drive.
- R8: When `flag_clr` coincides with a fault edge, `fault_flag` stays 1.
- R9: After reset, `fault_flag` and `irq` are 0 and `pad_drive` equals `ch_oe`.
- R10: A steady input level is not a fault, including when its polarity select bit is changed while the level is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fd_en | input | 1 | Master fault detection enable |
| cmp_en | input | 1 | Comparator source enable |
| cmp_fall | input | 1 | Comparator active edge: 0 rising, 1 falling |
| pin_en | input | 1 | Fault pin source enable |
| pin_fall | input | 1 | Fault pin active edge: 0 rising, 1 falling |
| hiz_mode | input | 1 | 1: a fault removes pad drive |
| irq_en | input | 1 | Fault interrupt enable |
| flag_clr | input | 1 | Software clear pulse for the fault flag |
| cmp_in | input | 1 | Comparator result, asynchronous |
| flt_in | input | 1 | External fault pin, asynchronous |
| ch_oe | input | NCH | Per-channel output enable |
| pad_drive | output | NCH | Per-pad drive enable (0 = high impedance) |
| fault_flag | output | 1 | Latched fault flag |
| irq | output | 1 | Fault interrupt request |

## Verification
The assertions assume that `flag_clr` is a software pulse and that the control bits are quasi-static. Control bits change only while no edge is in flight in the synchronizers. The bench follows this by setting each input's starting level with the master enable off, waiting for the chain to settle and clearing the flag, and only then enabling the sources and making a single edge. The asynchronous inputs are changed only on falling clock edges, so the synchronizer latency is deterministic and the edge-to-flag timing can be checked to the cycle.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_sel_e;

   // Picks the detected edge that matches the selected polarity.
   function automatic logic edge_pick(input edge_sel_e sel, input logic rise, input logic fall);
      return (sel == EDGE_FALL) ? fall : rise;
   endfunction
endpackage

// File: rtl/fault_sync_edge.sv
module fault_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise,
   output logic fall
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] chain;
   logic          prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("fault_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= '0;
         prev_q <= 1'b0;
      end else begin
         chain  <= {chain[LAST-1:0], async_in};
         prev_q <= chain[LAST];
      end
   end

   assign rise =  chain[LAST] & ~prev_q;
   assign fall = ~chain[LAST] &  prev_q;
endmodule

// File: rtl/fault_flag_latch.sv
module fault_flag_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (set_evt) flag <= 1'b1;   // a new fault beats a simultaneous clear
      else if (clr)     flag <= 1'b0;
   end
endmodule

// File: rtl/pad_kill.sv
module pad_kill #(
   parameter int NCH = 8
) (
   input  logic           kill,
   input  logic [NCH-1:0] ch_oe,
   output logic [NCH-1:0] pad_drive
);
   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         assign pad_drive[i] = ch_oe[i] & ~kill;
      end
   endgenerate
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
   import pwm_fault_pkg::*;
#(
   parameter int NCH         = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           fd_en,
   input  logic           cmp_en,
   input  logic           cmp_fall,
   input  logic           pin_en,
   input  logic           pin_fall,
   input  logic           hiz_mode,
   input  logic           irq_en,
   input  logic           flag_clr,
   input  logic           cmp_in,
   input  logic           flt_in,
   input  logic [NCH-1:0] ch_oe,
   output logic [NCH-1:0] pad_drive,
   output logic           fault_flag,
   output logic           irq
);
   localparam int NSRC = 2;

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("pwm_fault_guard: NCH must be at least 1");
      end
   endgenerate

   logic [NSRC-1:0] src_in, src_en, src_rise, src_fall, src_hit;
   edge_sel_e       src_sel [NSRC];

   assign src_in  = {flt_in, cmp_in};
   assign src_en  = {pin_en, cmp_en};
   assign src_sel[0] = edge_sel_e'(cmp_fall);
   assign src_sel[1] = edge_sel_e'(pin_fall);

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         fault_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (src_in[s]),
            .rise     (src_rise[s]),
            .fall     (src_fall[s])
         );
         assign src_hit[s] = src_en[s] & edge_pick(src_sel[s], src_rise[s], src_fall[s]);
      end
   endgenerate

   logic fault_evt;
   assign fault_evt = fd_en & (|src_hit);

   fault_flag_latch u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (fault_evt),
      .clr     (flag_clr),
      .flag    (fault_flag)
   );

   pad_kill #(.NCH(NCH)) u_pads (
      .kill      (fault_flag & hiz_mode),
      .ch_oe     (ch_oe),
      .pad_drive (pad_drive)
   );

   assign irq = fault_flag & irq_en;
endmodule

// File: rtl/pwm_fault_guard_chk.sv
module pwm_fault_guard_chk #(
   parameter int NCH = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           fd_en,
   input logic           hiz_mode,
   input logic           irq_en,
   input logic           flag_clr,
   input logic [NCH-1:0] ch_oe,
   input logic [NCH-1:0] pad_drive,
   input logic           fault_flag,
   input logic           irq
);
   AST_OFF_NO_SET:   assert property (@(posedge clk) disable iff (!rst_n)
                        (!fault_flag && !fd_en) |=> !fault_flag);                  // R1
   AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
                        $rose(fault_flag) |-> $past(fd_en));                       // R1
   AST_IRQ_FLAG:     assert property (@(posedge clk) disable iff (!rst_n)
                        irq |-> fault_flag);                                       // R5
   AST_IRQ_GATED:    assert property (@(posedge clk) disable iff (!rst_n)
                        !irq_en |-> !irq);                                         // R5
   AST_HIZ_KILL:     assert property (@(posedge clk) disable iff (!rst_n)
                        (fault_flag && hiz_mode) |-> (pad_drive == '0));           // R6
   AST_PAD_SUBSET:   assert property (@(posedge clk) disable iff (!rst_n)
                        (pad_drive & ~ch_oe) == '0);                               // R6
   AST_PAD_PASS:     assert property (@(posedge clk) disable iff (!rst_n)
                        (!fault_flag || !hiz_mode) |-> (pad_drive == ch_oe));      // R6
   AST_FLAG_STICKY:  assert property (@(posedge clk) disable iff (!rst_n)
                        (fault_flag && !flag_clr) |=> fault_flag);                 // R7
endmodule

bind pwm_fault_guard pwm_fault_guard_chk #(.NCH(NCH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fd_en      (fd_en),
   .hiz_mode   (hiz_mode),
   .irq_en     (irq_en),
   .flag_clr   (flag_clr),
   .ch_oe      (ch_oe),
   .pad_drive  (pad_drive),
   .fault_flag (fault_flag),
   .irq        (irq)
);

// File: tb/sim_pwm_fault_guard.sv
module sim_pwm_fault_guard;
   localparam int NCH = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic fd_en = 0, cmp_en = 0, cmp_fall = 0, pin_en = 0, pin_fall = 0;
   logic hiz_mode = 0, irq_en = 0, flag_clr = 0, cmp_in = 0, flt_in = 0;
   logic [NCH-1:0] ch_oe = 8'hA5;
   logic [NCH-1:0] pad_drive;
   logic fault_flag, irq;

   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   pwm_fault_guard #(.NCH(NCH)) u0 (
      .clk(clk), .rst_n(rst_n), .fd_en(fd_en), .cmp_en(cmp_en), .cmp_fall(cmp_fall),
      .pin_en(pin_en), .pin_fall(pin_fall), .hiz_mode(hiz_mode), .irq_en(irq_en),
      .flag_clr(flag_clr), .cmp_in(cmp_in), .flt_in(flt_in), .ch_oe(ch_oe),
      .pad_drive(pad_drive), .fault_flag(fault_flag), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clocks(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Settle inputs with detection off, then clear the flag.
   task automatic prep(input logic c_lvl, input logic f_lvl);
      fd_en = 0; cmp_in = c_lvl; flt_in = f_lvl;
      clocks(4);
      flag_clr = 1; clocks(1); flag_clr = 0;
   endtask

   // Vector bits: {exp, dir_fall, src_pin, pin_fall, pin_en, cmp_fall, cmp_en, fd_en}
   localparam int NV = 11;
   localparam logic [7:0] VEC [NV] = '{
      8'b1000_0011,  // R2 cmp rise, sel rise
      8'b1100_0111,  // R2 cmp fall, sel fall
      8'b0100_0011,  // R2 cmp fall, sel rise
      8'b0000_0111,  // R2 cmp rise, sel fall
      8'b0000_0001,  // R2 cmp disabled
      8'b1010_1001,  // R3 pin rise, sel rise
      8'b1111_1001,  // R3 pin fall, sel fall
      8'b0011_1001,  // R3 pin rise, sel fall
      8'b0010_0001,  // R3 pin disabled
      8'b0000_0010,  // R1 master off, cmp
      8'b0010_1000   // R1 master off, pin
   };

   initial begin
      int wd = 0;
      forever begin
         @(posedge clk);
         wd++;
         if (wd > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin
      clocks(3);
      // R9 reset state
      check("R9 flag", fault_flag, 0);
      check("R9 irq", irq, 0);
      check("R9 pad", pad_drive, ch_oe);
      @(negedge clk) rst_n = 1;
      clocks(2);
      check("R9 flag after release", fault_flag, 0);

      for (int v = 0; v < NV; v++) begin
         logic [7:0] w;
         logic lvl;
         w = VEC[v];
         lvl = w[6];                         // falling edge starts high
         prep(w[5] ? cmp_in : lvl, w[5] ? lvl : flt_in);
         if (w[5]) flt_in = lvl; else cmp_in = lvl;
         prep(cmp_in, flt_in);
         cmp_en = w[1]; cmp_fall = w[2]; pin_en = w[3]; pin_fall = w[4];
         fd_en = w[0];
         if (w[5]) flt_in = ~lvl; else cmp_in = ~lvl;
         clocks(4);
         check(w[5] ? "R3 vector" : (w[0] ? "R2 vector" : "R1 vector"), fault_flag, w[7]);
      end

      // R4 latency and R5 flag without interrupt enable
      prep(0, 0);
      cmp_en = 1; cmp_fall = 0; pin_en = 0; irq_en = 0; hiz_mode = 0; fd_en = 1;
      cmp_in = 1;
      clocks(2);
      check("R4 not yet", fault_flag, 0);
      clocks(1);
      check("R4 third edge", fault_flag, 1);
      check("R5 no irq when disabled", irq, 0);
      check("R6 no override in hold mode", pad_drive, ch_oe);
      irq_en = 1; #1;
      check("R5 irq", irq, 1);
      hiz_mode = 1; #1;
      check("R6 pads off", pad_drive, 8'h00);
      ch_oe = 8'h3C; #1;
      check("R6 pads off other oe", pad_drive, 8'h00);

      // R8 clear coincident with new fault edge
      cmp_in = 0; clocks(4);            // falling edge ignored (rise selected)
      cmp_in = 1; clocks(2);
      flag_clr = 1; clocks(1); flag_clr = 0;
      check("R8 fault beats clear", fault_flag, 1);

      // R7 clear
      flag_clr = 1; clocks(1); flag_clr = 0;
      check("R7 cleared", fault_flag, 0);
      check("R7 pads restored", pad_drive, 8'h3C);
      check("R7 irq drop", irq, 0);

      // R10 steady level, polarity flipped while held
      cmp_fall = 1; clocks(4);
      cmp_fall = 0; clocks(4);
      check("R10 steady level", fault_flag, 0);
      check("R10 pads", pad_drive, 8'h3C);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule